// File: doc/BRIEF.md
# Tick-Paced Saturating Up-Counter

This block keeps an 8-bit count that climbs by one on each slow timing tick while its active-low run input is held low. It stays where it is while that input is high. The ticks come from an internal down-counting prescaler that runs on the same fast system clock as the count. No divided clock is ever created, so every flop shares one clock domain. The prescaler division ratio is a parameter set to the input clock frequency in hertz. The default of 50,000,000 gives one tick per second.

The count never wraps. When it reaches its top value of 255 it stays there until a reset, and the prescaler stops moving at the same time. A synchronous reset clears the count and restarts the prescaler phase. Reset wins over both the tick and the run input. The count is a plain output, and there is no stream interface, so the block has no back-pressure rules.

Top module: `tick_sat_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, `count_o` is 0 after that edge.
- R2: When a tick falls on a rising edge, `rst` is 0 and `run_n` is 0, `count_o` rises by exactly one at that edge (below 255). At any other edge it never changes by more than one.
- R3: While `run_n` is 1, `count_o` holds its value, even across ticks.
- R4: Once `count_o` is 255 it stays 255 for every later edge until reset. While it is 255 the prescaler state is frozen.
- R5: Ticks fall on every TICK_DIV-th rising edge. The first tick falls on the TICK_DIV-th edge after the last reset edge.
- R6: Reset takes priority: a reset edge that coincides with a tick and `run_n` = 0 still leaves `count_o` at 0.
- R7: Reset reloads the prescaler, so a reset in the middle of a tick period restarts the full TICK_DIV-edge wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Active-low count enable: 0 lets ticks advance the count, 1 holds it |
| count_o | output | CNT_W (8) | Current count value, saturating at 2**CNT_W-1 |

## Verification
Each result is registered once, so a tick, reset or run input sampled at a rising edge shows up on `count_o` right after that same edge. The bench drives inputs on falling edges and advances a behavioural model on each rising edge. It compares the model with `count_o` on the next falling edge, one check per clock. Directed checks then pin the exact edges that matter: no change after TICK_DIV-1 edges and the first step on edge TICK_DIV after reset. They also cover a reset in the middle of a period and the value after more than 255 enabled ticks.

// File: rtl/sat_cnt_pkg.sv
package sat_cnt_pkg;
  localparam int unsigned DEF_CNT_W   = 8;
  localparam int unsigned DEF_TICK_DIV = 50_000_000;

  function automatic int unsigned div_width(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction
endpackage

// File: rtl/sat_cnt_prescale.sv
module sat_cnt_prescale
  import sat_cnt_pkg::*;
#(
  parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = !freeze && !rst;
    end else begin : g_div
      localparam int unsigned PW = div_width(TICK_DIV);
      localparam logic [PW-1:0] RELOAD = PW'(TICK_DIV - 1);
      logic [PW-1:0] left;

      always_ff @(posedge clk) begin
        if (rst)
          left <= RELOAD;
        else if (!freeze)
          left <= (left == '0) ? RELOAD : left - 1'b1;
      end

      assign tick = (left == '0) && !freeze;

      AST_RELOAD_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tick |=> (left == RELOAD)); // R5
      AST_FROZEN_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(left)); // R4
      AST_RESET_RELOADS: assert property (@(posedge clk)
        rst |=> (left == RELOAD)); // R7
    end
  endgenerate
endmodule

// File: rtl/sat_cnt_core.sv
module sat_cnt_core
  import sat_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             run_n,
  output logic [CNT_W-1:0] count,
  output logic             at_top
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign at_top = (count == TOP);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (step && !run_n && !at_top)
      count <= count + 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (count == '0)); // R1
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP)); // R4
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)); // R2
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    run_n |=> $stable(count)); // R3
endmodule

// File: rtl/tick_sat_counter.sv
module tick_sat_counter
  import sat_cnt_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_n,
  output logic [CNT_W-1:0] count_o
);
  logic tick;
  logic at_top;

  sat_cnt_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .freeze (at_top),
    .tick   (tick)
  );

  sat_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .step   (tick),
    .run_n  (run_n),
    .count  (count_o),
    .at_top (at_top)
  );

  AST_RESET_BEATS_TICK: assert property (@(posedge clk)
    (rst && tick && !run_n) |=> (count_o == '0)); // R6
endmodule

// File: tb/tick_sat_counter_tb.sv
`timescale 1ns/100ps
module tick_sat_counter_tb;
  localparam int DIV = 4;
  localparam int TOPV = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_n = 1'b1;
  logic [7:0] count_o;

  int n_run = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  int phase = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_sat_counter #(.CNT_W(8), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .run_n(run_n), .count_o(count_o)
  );

  // behavioural reference: cycles since the last tick or reset
  always @(posedge clk) begin
    if (rst) begin
      exp_cnt = 0;
      phase = 0;
    end else if (exp_cnt != TOPV) begin
      if (phase == DIV - 1) begin
        phase = 0;
        if (!run_n) exp_cnt = exp_cnt + 1;
      end else begin
        phase = phase + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_run++;
      if (int'(count_o) != exp_cnt) begin
        n_fail++;
        $display("FAIL %s per-cycle: count_o=%0d expected %0d", cur_req, count_o, exp_cnt);
      end
    end
  end

  task automatic check(input string req, input int want);
    n_run++;
    if (int'(count_o) != want) begin
      n_fail++;
      $display("FAIL %s directed: count_o=%0d expected %0d", req, count_o, want);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_up();
  end

  initial begin
    // R1: reset state
    edges(3);
    check("R1", 0);

    // R5: first tick lands on edge DIV after reset release
    cur_req = "R5";
    rst = 1'b0;
    run_n = 1'b0;
    edges(DIV - 1);
    check("R5", 0);
    edges(1);
    check("R5", 1);
    edges(DIV);
    check("R5", 2);

    // R2: steady counting
    cur_req = "R2";
    edges(DIV * 10);
    check("R2", 12);

    // R3: hold across several ticks
    cur_req = "R3";
    run_n = 1'b1;
    edges(DIV * 5);
    check("R3", 12);
    run_n = 1'b0;
    edges(DIV * 2);
    check("R2", 14);

    // R6: reset on the tick edge with run_n low (tick phase aligned)
    cur_req = "R6";
    edges(DIV - 1);
    rst = 1'b1;
    edges(1);
    check("R6", 0);

    // R7: reset in mid-period restarts the full wait
    cur_req = "R7";
    rst = 1'b0;
    edges(2);
    rst = 1'b1;
    edges(1);
    rst = 1'b0;
    edges(DIV - 1);
    check("R7", 0);
    edges(1);
    check("R7", 1);

    // R4: saturation after more than 255 enabled ticks
    cur_req = "R4";
    edges(DIV * 300);
    check("R4", 255);
    run_n = 1'b1;
    edges(DIV * 3);
    check("R4", 255);
    run_n = 1'b0;
    edges(DIV * 5);
    check("R4", 255);

    // R1: reset from saturation
    cur_req = "R1";
    rst = 1'b1;
    edges(1);
    check("R1", 0);
    rst = 1'b0;
    edges(DIV);
    check("R5", 1);

    finish_up();
  end
endmodule